// File: doc/BRIEF.md
# Bus Clock Divisor Pair Search Engine

This block picks the two clock-divider counts that set a serial bus clock: a sample count and a step count whose product divides a source clock down to a requested bus frequency. Given the source frequency and the target frequency, it steps through the sample counts in ascending order. For each one it finds the smallest step count that reaches the required division. It keeps the pair with the smallest product that is still not below the required divisor, and that never runs the bus faster than asked.

Software or a setup sequencer places both frequencies on the inputs and pulses `start`. A few hundred cycles later the block pulses `done` for one cycle and presents both counts encoded as value minus one. Alongside them it gives a flag saying whether the narrow high-speed step range was in force, and an error flag for targets it cannot reach. Each ceiling division runs on one shared serial restoring divider, so the block is small and slow, which suits a configuration-time helper.

The block has no streaming data path, so it uses no valid/ready pair. `start` and `done` are plain control pins. A `start` is taken only while the engine is idle, and there is no back-pressure: the results stay on the outputs until the next accepted request finishes, and the consumer may read them at any time after `done`.

Top module: `sclk_pair_finder`

## Requirements
- R1: A request with a target of zero is rejected: `done` rises on the first clock edge after `start`, with `unsupported`=1, both codes 0 and `hs_sel`=0.
- R2: When the clamped target exceeds 400000 Hz, `hs_sel`=1 and the step count is limited to 8, so `step_code` is at most 7. Otherwise, including exactly 400000 Hz, `hs_sel`=0 and the limit is 64.
- R3: A target above 3400000 Hz produces exactly the same outputs as a target of 3400000 Hz.
- R4: The required divisor is ceil(floor(source/2) / target). Sample counts 1 to 8 are tried in ascending order, each with step = ceil(divisor / sample). A candidate whose step exceeds the limit is skipped. A candidate replaces the best pair only when its product is strictly smaller, so on a tie the smaller sample count wins.
- R5: When no candidate fits within the limit, the result is the fallback pair: sample 8 and step equal to the limit.
- R6: `unsupported`=1 when floor(source / (2 × sample × step)) is greater than the clamped target for the chosen pair, and 0 otherwise.
- R7: `sample_code` = sample − 1 (3 bits) and `step_code` = step − 1 (6 bits).
- R8: `done` is high for exactly one cycle per accepted request. All result outputs keep their values from one `done` to the next, and they are 0 after reset.
- R9: A `start` that arrives while a search is running is ignored and does not change that search's result.
- R10: The search stops as soon as a kept candidate's product equals the divisor exactly, so such a request completes sooner than one that tries all eight sample counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken when idle |
| src_hz | input | 32 | Source clock frequency in Hz |
| tgt_hz | input | 32 | Target bus frequency in Hz |
| done | output | 1 | One-cycle completion pulse |
| sample_code | output | 3 | Chosen sample count minus one |
| step_code | output | 6 | Chosen step count minus one |
| hs_sel | output | 1 | Narrow high-speed step limit was used |
| unsupported | output | 1 | Target too low (or zero) to reach |

## Verification
The bench builds the block with its default parameters: 32-bit frequencies, sample counts up to 8, a step limit of 64 below the 400 kHz edge and 8 above it, and the 3.4 MHz clamp. With these values, real source and target frequencies can drive every path of the search. This includes exact matches at the first and fifth sample counts, candidates skipped for exceeding either limit, the fallback pair in both ranges, the unsupported verdict, and both sides of the 400 kHz edge and the clamp. The bench checks each result against its own model of the search.

// File: rtl/sclk_pair_pkg.sv
package sclk_pair_pkg;
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_RDIV,
    PS_LAUNCH,
    PS_CAND,
    PS_FINAL
  } pair_state_e;
endpackage

// File: rtl/sclk_pair_div.sv
// Serial restoring divider producing a ceiling quotient; one bit per cycle.
module sclk_pair_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         fin,
  output logic [W-1:0] ceil_q
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  den_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          fin_q;
  logic [W:0]    shifted;
  logic [W+1:0]  trial;

  always_comb begin
    shifted = {rem_q[W-1:0], quo_q[W-1]};
    trial   = {1'b0, shifted} - {2'b00, den_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else if (go) begin
      rem_q <= '0;
      quo_q <= num;
      den_q <= den;
      cnt_q <= CW'(W);
      run_q <= 1'b1;
      fin_q <= 1'b0;
    end else if (run_q) begin
      rem_q <= trial[W+1] ? shifted : trial[W:0];
      quo_q <= {quo_q[W-2:0], ~trial[W+1]};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_q <= 1'b0;
        fin_q <= 1'b1;
      end
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign fin    = fin_q;
  assign ceil_q = quo_q + W'(rem_q != '0);

  AST_DIV_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (rem_q < {1'b0, den_q}));  // R4
endmodule

// File: rtl/sclk_pair_best.sv
// Keeps the smallest-product candidate seen since the last init.
module sclk_pair_best #(
  parameter int FREQ_W     = 32,
  parameter int SAMPLE_MAX = 8,
  parameter int STEP_LO    = 64
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               init,
  input  logic [$clog2(STEP_LO):0]           lim,
  input  logic                               cand_en,
  input  logic [$clog2(SAMPLE_MAX):0]        cand_s,
  input  logic [FREQ_W-1:0]                  cand_step,
  output logic                               upd,
  output logic [$clog2(SAMPLE_MAX)+$clog2(STEP_LO)+1:0] cand_prod,
  output logic [$clog2(SAMPLE_MAX):0]        best_s,
  output logic [$clog2(STEP_LO):0]           best_step,
  output logic [$clog2(SAMPLE_MAX)+$clog2(STEP_LO)+1:0] best_p
);
  localparam int SV_W = $clog2(SAMPLE_MAX) + 1;
  localparam int TV_W = $clog2(STEP_LO) + 1;
  localparam int PW   = SV_W + TV_W;

  logic fits;

  always_comb begin
    fits      = cand_step <= FREQ_W'(lim);
    cand_prod = PW'(cand_s) * PW'(cand_step[TV_W-1:0]);
    upd       = cand_en && fits && (cand_prod < best_p);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_s    <= '0;
      best_step <= '0;
      best_p    <= '0;
    end else if (init) begin
      best_s    <= SV_W'(SAMPLE_MAX);
      best_step <= lim;
      best_p    <= PW'(SAMPLE_MAX) * PW'(lim);
    end else if (upd) begin
      best_s    <= cand_s;
      best_step <= cand_step[TV_W-1:0];
      best_p    <= cand_prod;
    end
  end

  AST_BEST_NEVER_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    !init |=> (best_p <= $past(best_p)));  // R4
  AST_BEST_STEP_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> (cand_step <= FREQ_W'(lim)));  // R5
endmodule

// File: rtl/sclk_pair_finder.sv
module sclk_pair_finder #(
  parameter int FREQ_W     = 32,
  parameter int SAMPLE_MAX = 8,
  parameter int STEP_LO    = 64,
  parameter int STEP_HI    = 8,
  parameter int HS_CAP     = 3400000,
  parameter int FS_EDGE    = 400000
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [FREQ_W-1:0]               src_hz,
  input  logic [FREQ_W-1:0]               tgt_hz,
  output logic                            done,
  output logic [$clog2(SAMPLE_MAX)-1:0]   sample_code,
  output logic [$clog2(STEP_LO)-1:0]      step_code,
  output logic                            hs_sel,
  output logic                            unsupported
);
  import sclk_pair_pkg::*;

  localparam int SC_W = $clog2(SAMPLE_MAX);
  localparam int ST_W = $clog2(STEP_LO);
  localparam int SV_W = SC_W + 1;
  localparam int TV_W = ST_W + 1;
  localparam int PW   = SV_W + TV_W;
  localparam int MW   = FREQ_W + PW + 2;

  pair_state_e       st_q;
  logic [FREQ_W-1:0] src_q, tgt_q, need_q;
  logic              hs_q;
  logic [SV_W-1:0]   s_q;

  logic [FREQ_W-1:0] clamp;
  logic              clamp_hs;
  logic [TV_W-1:0]   lim;
  logic              div_go, div_fin;
  logic [FREQ_W-1:0] div_num, div_den, div_ceil;
  logic              best_init, cand_en, upd, hit;
  logic [PW-1:0]     cand_prod, best_p;
  logic [SV_W-1:0]   best_s;
  logic [TV_W-1:0]   best_step;
  logic [MW-1:0]     bound;
  logic              too_slow;

  always_comb begin
    clamp     = (tgt_hz > FREQ_W'(HS_CAP)) ? FREQ_W'(HS_CAP) : tgt_hz;
    clamp_hs  = clamp > FREQ_W'(FS_EDGE);
    lim       = hs_q ? TV_W'(STEP_HI) : TV_W'(STEP_LO);
    div_go    = ((st_q == PS_IDLE) && start && (tgt_hz != '0)) || (st_q == PS_LAUNCH);
    div_num   = (st_q == PS_IDLE) ? (src_hz >> 1) : need_q;
    div_den   = (st_q == PS_IDLE) ? clamp : FREQ_W'(s_q);
    best_init = (st_q == PS_RDIV) && div_fin;
    cand_en   = (st_q == PS_CAND) && div_fin;
    hit       = upd && (FREQ_W'(cand_prod) == need_q);
    // floor(src/(2p)) > t  <=>  src >= 2p(t+1)
    bound     = (MW'(best_p) * (MW'(tgt_q) + MW'(1))) << 1;
    too_slow  = MW'(src_q) >= bound;
  end

  sclk_pair_div #(.W(FREQ_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .num   (div_num),
    .den   (div_den),
    .fin   (div_fin),
    .ceil_q(div_ceil)
  );

  sclk_pair_best #(
    .FREQ_W    (FREQ_W),
    .SAMPLE_MAX(SAMPLE_MAX),
    .STEP_LO   (STEP_LO)
  ) u_best (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (best_init),
    .lim      (lim),
    .cand_en  (cand_en),
    .cand_s   (s_q),
    .cand_step(div_ceil),
    .upd      (upd),
    .cand_prod(cand_prod),
    .best_s   (best_s),
    .best_step(best_step),
    .best_p   (best_p)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= PS_IDLE;
      src_q       <= '0;
      tgt_q       <= '0;
      need_q      <= '0;
      hs_q        <= 1'b0;
      s_q         <= '0;
      done        <= 1'b0;
      sample_code <= '0;
      step_code   <= '0;
      hs_sel      <= 1'b0;
      unsupported <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        PS_IDLE: begin
          if (start) begin
            if (tgt_hz == '0) begin
              sample_code <= '0;
              step_code   <= '0;
              hs_sel      <= 1'b0;
              unsupported <= 1'b1;
              done        <= 1'b1;
            end else begin
              src_q <= src_hz;
              tgt_q <= clamp;
              hs_q  <= clamp_hs;
              st_q  <= PS_RDIV;
            end
          end
        end
        PS_RDIV: begin
          if (div_fin) begin
            need_q <= div_ceil;
            s_q    <= SV_W'(1);
            st_q   <= PS_LAUNCH;
          end
        end
        PS_LAUNCH: st_q <= PS_CAND;
        PS_CAND: begin
          if (div_fin) begin
            if (hit || (s_q == SV_W'(SAMPLE_MAX))) begin
              st_q <= PS_FINAL;
            end else begin
              s_q  <= s_q + 1'b1;
              st_q <= PS_LAUNCH;
            end
          end
        end
        PS_FINAL: begin
          sample_code <= SC_W'(best_s - 1'b1);
          step_code   <= ST_W'(best_step - 1'b1);
          hs_sel      <= hs_q;
          unsupported <= too_slow;
          done        <= 1'b1;
          st_q        <= PS_IDLE;
        end
        default: st_q <= PS_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({sample_code, step_code, hs_sel, unsupported}));  // R8
  AST_ZERO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == PS_IDLE) && start && (tgt_hz == '0)) |=> (done && unsupported));  // R1
  AST_HS_STEP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hs_sel) |-> (int'(step_code) < STEP_HI));  // R2
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_CAND && !div_fin) |=> (st_q == PS_CAND));  // R9
endmodule

// File: tb/tb_sclk_pair_finder.sv
module tb_sclk_pair_finder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] src_hz = '0;
  logic [31:0] tgt_hz = '0;
  logic        done;
  logic [2:0]  sample_code;
  logic [5:0]  step_code;
  logic        hs_sel;
  logic        unsupported;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;  // 50 MHz

  sclk_pair_finder dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_hz(src_hz), .tgt_hz(tgt_hz),
    .done(done), .sample_code(sample_code), .step_code(step_code),
    .hs_sel(hs_sel), .unsupported(unsupported)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Model of the search from the requirements (R2..R7).
  task automatic model(input longint src, input longint tgt, output int smp, output int stp,
                       output bit hs, output bit err);
    longint t, need, best, lim, c;
    if (tgt == 0) begin
      smp = 1; stp = 1; hs = 0; err = 1;
      return;
    end
    t    = (tgt > 3400000) ? 3400000 : tgt;
    hs   = t > 400000;
    lim  = hs ? 8 : 64;
    need = ((src >> 1) + t - 1) / t;
    best = 8 * lim; smp = 8; stp = int'(lim);
    for (int s = 1; s <= 8; s++) begin
      c = (need + s - 1) / s;
      if (c > lim) continue;
      if (s * c < best) begin
        best = s * c; smp = s; stp = int'(c);
        if (best == need) break;
      end
    end
    err = (src / (2 * smp * stp)) > t;
  endtask

  task automatic run_req(input longint src, input longint tgt, output int lat);
    @(negedge clk);
    src_hz = 32'(src); tgt_hz = 32'(tgt); start = 1'b1; lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!done && lat < 5000);
    chk(done === 1'b1, "R8 done seen", longint'(done), 1);
  endtask

  task automatic chk_out(input longint src, input longint tgt, input string tag);
    int smp, stp; bit hs, err;
    model(src, tgt, smp, stp, hs, err);
    chk(int'(sample_code) == smp - 1, {tag, " R7 sample_code"}, sample_code, smp - 1);
    chk(int'(step_code) == ((stp - 1) & 63), {tag, " R4 step_code"}, step_code, (stp - 1) & 63);
    chk(hs_sel == hs, {tag, " R2 hs_sel"}, hs_sel, hs);
    chk(unsupported == err, {tag, " R6 unsupported"}, unsupported, err);
  endtask

  task automatic t_reset;
    chk(done == 0 && sample_code == 0 && step_code == 0 && hs_sel == 0 && unsupported == 0,
        "R8 reset state", {sample_code, step_code, hs_sel, unsupported, done}, 0);
  endtask

  task automatic t_zero;
    int lat;
    run_req(50000000, 0, lat);
    chk(lat == 1, "R1 zero target latency", lat, 1);
    chk(unsupported == 1 && sample_code == 0 && step_code == 0 && hs_sel == 0,
        "R1 zero target outputs", {sample_code, step_code, hs_sel, unsupported}, 1);
  endtask

  task automatic t_standard;
    int lat;
    run_req(50000000, 100000, lat);
    chk(sample_code == 4 && step_code == 49, "R4 pair for 50M/100k",
        {sample_code, step_code}, {3'd4, 6'd49});
    chk_out(50000000, 100000, "std");
  endtask

  task automatic t_mixed;
    longint srcs[4] = '{26000000, 40000000, 133000000, 13000000};
    longint tgts[4] = '{100000, 333000, 250000, 1000000};
    int lat;
    for (int i = 0; i < 4; i++) begin
      run_req(srcs[i], tgts[i], lat);
      chk_out(srcs[i], tgts[i], "R4 mixed");
    end
  endtask

  task automatic t_highspeed;
    int lat;
    run_req(50000000, 1000000, lat);
    chk(hs_sel == 1 && sample_code == 4 && step_code == 4, "R2 high speed pair",
        {hs_sel, sample_code, step_code}, {1'b1, 3'd4, 6'd4});
    chk_out(50000000, 1000000, "hs");
  endtask

  task automatic t_edge;
    int lat;
    run_req(50000000, 400000, lat);
    chk(hs_sel == 0, "R2 edge 400000 wide limit", hs_sel, 0);
    chk_out(50000000, 400000, "edge0");
    run_req(50000000, 400001, lat);
    chk(hs_sel == 1, "R2 edge 400001 narrow limit", hs_sel, 1);
    chk_out(50000000, 400001, "edge1");
  endtask

  task automatic t_clamp;
    int lat;
    logic [10:0] a, b;
    run_req(100000000, 3400000, lat);
    a = {sample_code, step_code, hs_sel, unsupported};
    run_req(100000000, 5000000, lat);
    b = {sample_code, step_code, hs_sel, unsupported};
    chk(a == b, "R3 clamp above 3.4MHz", b, a);
  endtask

  task automatic t_fallback;
    int lat;
    run_req(200000000, 1000, lat);
    chk(sample_code == 7 && step_code == 63 && unsupported == 1, "R5 R6 fallback wide",
        {sample_code, step_code, unsupported}, {3'd7, 6'd63, 1'b1});
    run_req(200000000, 500000, lat);
    chk(sample_code == 7 && step_code == 7 && hs_sel == 1 && unsupported == 1,
        "R5 fallback narrow", {sample_code, step_code, unsupported}, {3'd7, 6'd7, 1'b1});
  endtask

  task automatic t_early;
    int l_exact, l_full;
    run_req(2000000, 400000, l_exact);
    chk_out(2000000, 400000, "R10 exact first");
    run_req(200000000, 1000, l_full);
    chk(l_exact < l_full, "R10 early exit latency", l_exact, l_full);
  endtask

  task automatic t_hold;
    logic [10:0] snap;
    int lat;
    run_req(50000000, 100000, lat);
    snap = {sample_code, step_code, hs_sel, unsupported};
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      src_hz = 32'(i * 12345); tgt_hz = 32'(i);
    end
    chk({sample_code, step_code, hs_sel, unsupported} == snap && done == 0,
        "R8 outputs hold after done", {sample_code, step_code, hs_sel, unsupported}, snap);
  endtask

  task automatic t_busy;
    int lat;
    @(negedge clk);
    src_hz = 50000000; tgt_hz = 1000000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    tgt_hz = 0; src_hz = 7; start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 0;
    while (!done && lat < 5000) begin @(negedge clk); lat++; end
    chk(done == 1 && hs_sel == 1 && unsupported == 0, "R9 start ignored while busy",
        {hs_sel, unsupported}, 2);
    chk_out(50000000, 1000000, "R9 busy result");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_standard();
    t_mixed();
    t_highspeed();
    t_edge();
    t_clamp();
    t_fallback();
    t_early();
    t_hold();
    t_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule